// File: doc/BRIEF.md
# Per-Stream Last-Page Address Translator

This block sits between the address generators of a processor and its TLB. It keeps one translation register per access stream and per hardware thread. Each register holds the most recent virtual page seen on that stream, the context number it was translated under, and the physical page it maps to. Pages are 4 KB. The low twelve address bits pass straight through, so only the upper page bits are compared and replaced.

A request names a thread, a stream, a context number and a 32-bit virtual address. If the stream's register is valid and both the page and the context match, the translated address is returned in the same cycle and the TLB sees no traffic. Otherwise the block raises a single lookup on a valid/ready handshake towards the TLB. It then waits for the response, returns the physical address (or an error flag on a fault), and refreshes the stream's register. A single invalidate-all pulse empties every register whenever the address mapping changes.

Streams are encoded on `req_stream` as 0 = instruction fetch, 1 = first data operand, 2 = second data operand, 3 = stack.

Top module: `page_xlat_front`

## Requirements
- R1: Bits 11:0 of `resp_paddr` equal bits 11:0 of `req_vaddr` on every completed request, for every offset value including 0x000 and 0xFFF.
- R2: A request hits only when the register selected by `{req_thread, req_stream}` is valid and its stored page and stored context both equal the request's. A hit sets `req_ready` high in the cycle the request is presented and raises no TLB lookup.
- R3: On a hit, `resp_paddr` is the stored physical page followed by the request's offset, and `resp_err` is 0.
- R4: On a miss, `tlb_req_valid` is high in the request cycle, carrying the virtual page (`req_vaddr[31:12]`) and the context. It stays high while `tlb_req_ready` is low. `req_ready` stays low from the request cycle until the TLB response cycle, so a miss takes exactly (handshake stall cycles + response wait cycles + 2) cycles.
- R5: In the cycle `tlb_rsp_valid` is high with no fault, the request completes with `resp_paddr` = {`tlb_rsp_ppage`, offset} and `resp_err` = 0. The selected register is reloaded, so a later request to the same page and context hits.
- R6: Each thread/stream pair owns a separate register. Filling one register never changes the hit or result of any other.
- R7: A faulting response completes the request with `resp_err` = 1 and leaves the selected register unchanged. Its previous page still hits, and the faulting page misses again.
- R8: A one-cycle `inval_all` pulse clears every register from the next cycle on. The next request to any earlier page misses.
- R9: If `inval_all` pulses while a lookup is outstanding, the response is still returned to the requester but is not stored. A repeat of the same request misses again.
- R10: After reset every register is invalid, `req_ready` and `tlb_req_valid` are low, and the first request misses.
- R11: At most one lookup is outstanding. Once a lookup is accepted, `tlb_req_valid` stays low until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inval_all | input | 1 | Clears every translation register |
| req_valid | input | 1 | Request present; held with its fields until `req_ready` |
| req_thread | input | 1 | Hardware thread of the request |
| req_stream | input | 2 | Access stream (0 fetch, 1 operand A, 2 operand B, 3 stack) |
| req_ctx | input | 8 | Context number |
| req_vaddr | input | 32 | Virtual address |
| req_ready | output | 1 | Request completes this cycle |
| resp_paddr | output | 32 | Physical address, valid with `req_ready` |
| resp_err | output | 1 | Translation fault, valid with `req_ready` |
| tlb_req_valid | output | 1 | Lookup request to the TLB |
| tlb_req_ready | input | 1 | TLB accepts the lookup |
| tlb_req_vpage | output | 20 | Virtual page to look up |
| tlb_req_ctx | output | 8 | Context of the lookup |
| tlb_rsp_valid | input | 1 | TLB response present |
| tlb_rsp_ppage | input | 20 | Physical page from the TLB |
| tlb_rsp_fault | input | 1 | TLB reports no valid translation |

## Verification
The bench builds the block with its defaults: two threads, four streams, 8-bit contexts and 32-bit addresses. That gives eight independent registers, enough to fill every thread/stream pair and revisit each one to show isolation. A table-free TLB model (physical page = virtual page XOR a context-derived pattern, fault on top nibble 0xF) lets the bench stall the handshake and the response by chosen cycle counts. This exposes the exact miss latency, fault handling and invalidation that lands mid-lookup.

// File: rtl/lpx_pkg.sv
// Shared types for the per-stream last-page translator.
// Assumes a two-state miss sequence: idle or waiting on one TLB response.
package lpx_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/lpx_entry_bank.sv
// Register file of last-page translations, one entry per thread/stream pair.
// One write port and one combinational read port.
// Assumes inval_all has priority over a write in the same cycle.
module lpx_entry_bank #(
    parameter int NENT  = 8,
    parameter int VP_W  = 20,
    parameter int PP_W  = 20,
    parameter int CTX_W = 8,
    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VP_W-1:0]  wr_vpage,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [PP_W-1:0]  wr_ppage,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [VP_W-1:0]  rd_vpage,
    output logic [CTX_W-1:0] rd_ctx,
    output logic [PP_W-1:0]  rd_ppage
);
    logic             val_a [NENT];
    logic [VP_W-1:0]  vp_a  [NENT];
    logic [CTX_W-1:0] cx_a  [NENT];
    logic [PP_W-1:0]  pp_a  [NENT];

    for (genvar g = 0; g < NENT; g++) begin : gen_ent
        logic             val_q;
        logic [VP_W-1:0]  vp_q;
        logic [CTX_W-1:0] cx_q;
        logic [PP_W-1:0]  pp_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // Valid bit: cleared by reset or invalidate, set by a fill.
        always_ff @(posedge clk) begin
            if (!rst_n)         val_q <= 1'b0;
            else if (inval_all) val_q <= 1'b0;
            else if (sel)       val_q <= 1'b1;
        end

        // Translation payload: loaded on a fill that is not overridden.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vp_q <= '0;
                cx_q <= '0;
                pp_q <= '0;
            end else if (sel && !inval_all) begin
                vp_q <= wr_vpage;
                cx_q <= wr_ctx;
                pp_q <= wr_ppage;
            end
        end

        assign val_a[g] = val_q;
        assign vp_a[g]  = vp_q;
        assign cx_a[g]  = cx_q;
        assign pp_a[g]  = pp_q;
    end

    // Read port: select the entry addressed by the current request.
    always_comb begin
        rd_valid = val_a[rd_idx];
        rd_vpage = vp_a[rd_idx];
        rd_ctx   = cx_a[rd_idx];
        rd_ppage = pp_a[rd_idx];
    end
endmodule

// File: rtl/lpx_match.sv
// Hit detection for one selected entry: valid, page equal and context equal.
// Purely combinational; assumes the entry is already selected by the caller.
module lpx_match #(
    parameter int VP_W  = 20,
    parameter int CTX_W = 8
) (
    input  logic             ent_valid,
    input  logic [VP_W-1:0]  ent_vpage,
    input  logic [CTX_W-1:0] ent_ctx,
    input  logic [VP_W-1:0]  req_vpage,
    input  logic [CTX_W-1:0] req_ctx,
    output logic             hit
);
    // Compare page and context together; both must agree.
    always_comb begin
        hit = ent_valid && (ent_vpage == req_vpage) && (ent_ctx == req_ctx);
    end
endmodule

// File: rtl/lpx_miss_seq.sv
// Miss sequencer: issues one TLB lookup per miss, waits for the response,
// and decides whether the response may be stored. Assumes the requester
// holds its request stable until req_ready.
module lpx_miss_seq
    import lpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inval_all,
    input  logic req_valid,
    input  logic hit,
    input  logic tlb_req_ready,
    input  logic tlb_rsp_valid,
    input  logic tlb_rsp_fault,
    output logic tlb_req_valid,
    output logic req_ready,
    output logic resp_err,
    output logic fill_en,
    output logic rsp_sel
);
    seq_state_e state_q;
    logic       stale_q;
    logic       rsp_done;

    // Output decode from the current state and the request.
    always_comb begin
        tlb_req_valid = (state_q == SEQ_IDLE) && req_valid && !hit;
        rsp_done      = (state_q == SEQ_WAIT) && tlb_rsp_valid;
        req_ready     = ((state_q == SEQ_IDLE) && req_valid && hit) || rsp_done;
        resp_err      = rsp_done && tlb_rsp_fault;
        fill_en       = rsp_done && !tlb_rsp_fault && !stale_q && !inval_all;
        rsp_sel       = (state_q == SEQ_WAIT);
    end

    // State and staleness tracking across one outstanding lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            stale_q <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (tlb_req_valid && tlb_req_ready) begin
                        state_q <= SEQ_WAIT;
                        stale_q <= inval_all;
                    end
                end
                default: begin
                    if (inval_all)     stale_q <= 1'b1;
                    if (tlb_rsp_valid) state_q <= SEQ_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/page_xlat_front.sv
// Top of the per-stream last-page translator. Selects the entry for
// {thread, stream}, answers hits in the request cycle and routes misses
// through the sequencer to the TLB. Assumes page offset width OFF_W.
module page_xlat_front #(
    parameter int NTHREAD = 2,
    parameter int NSTREAM = 4,
    parameter int CTX_W   = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    localparam int VP_W   = VA_W - OFF_W,
    localparam int PP_W   = PA_W - OFF_W,
    localparam int TID_W  = (NTHREAD > 1) ? $clog2(NTHREAD) : 1,
    localparam int SID_W  = (NSTREAM > 1) ? $clog2(NSTREAM) : 1,
    localparam int NENT   = NTHREAD * NSTREAM,
    localparam int IDX_W  = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval_all,
    input  logic             req_valid,
    input  logic [TID_W-1:0] req_thread,
    input  logic [SID_W-1:0] req_stream,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_err,
    output logic             tlb_req_valid,
    input  logic             tlb_req_ready,
    output logic [VP_W-1:0]  tlb_req_vpage,
    output logic [CTX_W-1:0] tlb_req_ctx,
    input  logic             tlb_rsp_valid,
    input  logic [PP_W-1:0]  tlb_rsp_ppage,
    input  logic             tlb_rsp_fault
);
    logic [IDX_W-1:0] ent_idx;
    logic [VP_W-1:0]  req_vpage;
    logic [OFF_W-1:0] req_off;
    logic             ent_valid;
    logic [VP_W-1:0]  ent_vpage;
    logic [CTX_W-1:0] ent_ctx;
    logic [PP_W-1:0]  ent_ppage;
    logic             hit;
    logic             fill_en;
    logic             rsp_sel;

    // Split the request address and form the entry index.
    always_comb begin
        req_vpage = req_vaddr[VA_W-1:OFF_W];
        req_off   = req_vaddr[OFF_W-1:0];
        ent_idx   = IDX_W'(int'(req_thread) * NSTREAM + int'(req_stream));
    end

    lpx_entry_bank #(
        .NENT(NENT), .VP_W(VP_W), .PP_W(PP_W), .CTX_W(CTX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
        .wr_en(fill_en), .wr_idx(ent_idx),
        .wr_vpage(req_vpage), .wr_ctx(req_ctx), .wr_ppage(tlb_rsp_ppage),
        .rd_idx(ent_idx), .rd_valid(ent_valid), .rd_vpage(ent_vpage),
        .rd_ctx(ent_ctx), .rd_ppage(ent_ppage)
    );

    lpx_match #(.VP_W(VP_W), .CTX_W(CTX_W)) u_match (
        .ent_valid(ent_valid), .ent_vpage(ent_vpage), .ent_ctx(ent_ctx),
        .req_vpage(req_vpage), .req_ctx(req_ctx), .hit(hit)
    );

    lpx_miss_seq u_seq (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
        .req_valid(req_valid), .hit(hit),
        .tlb_req_ready(tlb_req_ready), .tlb_rsp_valid(tlb_rsp_valid),
        .tlb_rsp_fault(tlb_rsp_fault), .tlb_req_valid(tlb_req_valid),
        .req_ready(req_ready), .resp_err(resp_err),
        .fill_en(fill_en), .rsp_sel(rsp_sel)
    );

    // Result and lookup outputs: physical page from entry or TLB.
    always_comb begin
        resp_paddr    = rsp_sel ? {tlb_rsp_ppage, req_off} : {ent_ppage, req_off};
        tlb_req_vpage = req_vpage;
        tlb_req_ctx   = req_ctx;
    end
endmodule

// File: rtl/lpx_checker.sv
// Protocol checker for page_xlat_front, bound into every instance.
// Assumes synchronous active-low reset; all properties disabled in reset.
module lpx_checker #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            inval_all,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic [PA_W-1:0] resp_paddr,
    input logic            resp_err,
    input logic            tlb_req_valid,
    input logic            tlb_req_ready,
    input logic            tlb_rsp_valid
);
    // R1: offset always passes through on completion
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (resp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]));

    // R4: while a lookup is being raised the request cannot complete
    p_stall_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_valid |-> !req_ready);

    // R11: an accepted lookup is not followed by another request
    p_single_lookup_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req_valid && tlb_req_ready) |=> !tlb_req_valid);

    // R7: a fault flag only appears on a completing request
    p_err_completes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> req_ready);

    // R8: after invalidation no request can complete from a register
    p_inval_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (!req_ready || tlb_rsp_valid));
endmodule

bind page_xlat_front lpx_checker #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_lpx_chk (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .resp_paddr(resp_paddr),
    .resp_err(resp_err), .tlb_req_valid(tlb_req_valid),
    .tlb_req_ready(tlb_req_ready), .tlb_rsp_valid(tlb_rsp_valid)
);

// File: tb/tb_page_xlat_front.sv
// Directed bench: one task per scenario, TLB modelled by a formula.
module tb_page_xlat_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        inval_all;
    logic        req_valid;
    logic [0:0]  req_thread;
    logic [1:0]  req_stream;
    logic [7:0]  req_ctx;
    logic [31:0] req_vaddr;
    logic        req_ready;
    logic [31:0] resp_paddr;
    logic        resp_err;
    logic        tlb_req_valid;
    logic        tlb_req_ready;
    logic [19:0] tlb_req_vpage;
    logic [7:0]  tlb_req_ctx;
    logic        tlb_rsp_valid;
    logic [19:0] tlb_rsp_ppage;
    logic        tlb_rsp_fault;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    page_xlat_front dut (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
        .req_valid(req_valid), .req_thread(req_thread), .req_stream(req_stream),
        .req_ctx(req_ctx), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .resp_paddr(resp_paddr), .resp_err(resp_err),
        .tlb_req_valid(tlb_req_valid), .tlb_req_ready(tlb_req_ready),
        .tlb_req_vpage(tlb_req_vpage), .tlb_req_ctx(tlb_req_ctx),
        .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_ppage(tlb_rsp_ppage),
        .tlb_rsp_fault(tlb_rsp_fault)
    );

    function automatic logic [19:0] tlb_map(input logic [19:0] vp, input logic [7:0] cx);
        return vp ^ {cx, 12'h5A3};
    endfunction

    function automatic logic tlb_flt(input logic [19:0] vp);
        return vp[19:16] == 4'hF;
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Drive one request and play the TLB; report what was observed.
    task automatic access(input int th, input int st, input logic [7:0] cx,
                          input logic [31:0] va, input int rdly, input int wdly,
                          input bit inval_mid, output logic [31:0] pa,
                          output logic er, output int looks, output int cyc);
        int  cnt = 0;
        int  phase = 0;
        bit  done = 0;
        looks = 0;
        cyc   = 0;
        pa    = '0;
        er    = 1'b0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_thread = 1'(th);
        req_stream = 2'(st);
        req_ctx    = cx;
        req_vaddr  = va;
        while (!done) begin
            #1;
            if (phase == 0) begin
                if (req_ready) begin
                    pa = resp_paddr; er = resp_err; done = 1;
                end else if (cnt < rdly) begin
                    chk("R4", "lookup held", {31'b0, tlb_req_valid}, 32'd1);
                    cnt++;
                end else begin
                    chk("R4", "lookup page", {12'b0, tlb_req_vpage}, {12'b0, va[31:12]});
                    chk("R4", "lookup ctx", {24'b0, tlb_req_ctx}, {24'b0, cx});
                    tlb_req_ready = 1'b1;
                    looks++;
                    phase = 1;
                    cnt = 0;
                end
            end else begin
                tlb_req_ready = 1'b0;
                chk("R11", "no second lookup", {31'b0, tlb_req_valid}, 32'd0);
                inval_all = inval_mid && (cnt == 0);
                if (cnt < wdly) begin
                    #1;
                    chk("R4", "ready low while waiting", {31'b0, req_ready}, 32'd0);
                    cnt++;
                end else begin
                    tlb_rsp_valid = 1'b1;
                    tlb_rsp_ppage = tlb_map(va[31:12], cx);
                    tlb_rsp_fault = tlb_flt(va[31:12]);
                    #1;
                    chk("R5", "ready on response", {31'b0, req_ready}, 32'd1);
                    pa = resp_paddr; er = resp_err; done = 1;
                end
            end
            cyc++;
            @(negedge clk);
        end
        req_valid     = 1'b0;
        tlb_rsp_valid = 1'b0;
        tlb_rsp_fault = 1'b0;
        tlb_req_ready = 1'b0;
        inval_all     = 1'b0;
    endtask

    // Access with expectations on hit/miss, error and address.
    task automatic xa(input string rq, input int th, input int st, input logic [7:0] cx,
                      input logic [31:0] va, input int rdly, input int wdly,
                      input bit inval_mid, input bit exp_hit, input bit exp_err);
        logic [31:0] pa;
        logic        er;
        int          looks;
        int          cyc;
        access(th, st, cx, va, rdly, wdly, inval_mid, pa, er, looks, cyc);
        chk(rq, "lookup count", 32'(looks), exp_hit ? 32'd0 : 32'd1);
        chk(rq, "error flag", {31'b0, er}, {31'b0, exp_err});
        if (!exp_err)
            chk(rq, "paddr", pa, {tlb_map(va[31:12], cx), va[11:0]});
        chk(rq, "cycles", 32'(cyc), exp_hit ? 32'd1 : 32'(rdly + wdly + 2));
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R10", "ready idle", {31'b0, req_ready}, 32'd0);
        chk("R10", "no lookup idle", {31'b0, tlb_req_valid}, 32'd0);
        xa("R10", 0, 0, 8'h11, 32'h1234_5678, 0, 0, 0, 0, 0);
    endtask

    task automatic t_fill_hit();
        xa("R5", 0, 1, 8'h22, 32'h0040_1ABC, 2, 3, 0, 0, 0);
        xa("R2", 0, 1, 8'h22, 32'h0040_1000, 0, 0, 0, 1, 0);
        xa("R3", 0, 1, 8'h22, 32'h0040_1FFF, 0, 0, 0, 1, 0);
        xa("R1", 0, 1, 8'h22, 32'h0040_1555, 0, 0, 0, 1, 0);
    endtask

    task automatic t_ctx();
        xa("R2", 0, 1, 8'h23, 32'h0040_1ABC, 1, 0, 0, 0, 0);
        xa("R2", 0, 1, 8'h23, 32'h0040_1ABD, 0, 0, 0, 1, 0);
        xa("R2", 0, 1, 8'h22, 32'h0040_1ABD, 0, 1, 0, 0, 0);
    endtask

    task automatic t_streams();
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 4; s++)
                xa("R6", t, s, 8'h30, 32'h1000_0000 + 32'((t * 4 + s) << 12) + 32'h10, 0, 1, 0, 0, 0);
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 4; s++)
                xa("R6", t, s, 8'h30, 32'h1000_0000 + 32'((t * 4 + s) << 12) + 32'h20, 0, 0, 0, 1, 0);
    endtask

    task automatic t_fault();
        xa("R7", 1, 2, 8'h05, 32'h0ABC_D123, 0, 0, 0, 0, 0);
        xa("R7", 1, 2, 8'h05, 32'hF000_0444, 1, 1, 0, 0, 1);
        xa("R7", 1, 2, 8'h05, 32'h0ABC_D124, 0, 0, 0, 1, 0);
        xa("R7", 1, 2, 8'h05, 32'hF000_0448, 0, 2, 0, 0, 1);
    endtask

    task automatic t_inval();
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        xa("R8", 0, 0, 8'h30, 32'h1000_0030, 0, 0, 0, 0, 0);
        xa("R8", 1, 2, 8'h05, 32'h0ABC_D000, 0, 0, 0, 0, 0);
    endtask

    task automatic t_inval_wait();
        xa("R9", 0, 3, 8'h09, 32'h7777_7010, 0, 2, 1, 0, 0);
        xa("R9", 0, 3, 8'h09, 32'h7777_7020, 0, 0, 0, 0, 0);
        xa("R9", 0, 3, 8'h09, 32'h7777_7030, 0, 0, 0, 1, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; inval_all = 1'b0; req_valid = 1'b0; req_thread = '0;
        req_stream = '0; req_ctx = '0; req_vaddr = '0; tlb_req_ready = 1'b0;
        tlb_rsp_valid = 1'b0; tlb_rsp_ppage = '0; tlb_rsp_fault = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_hit();
        t_ctx();
        t_streams();
        t_fault();
        t_inval();
        t_inval_wait();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule